// File: doc/BRIEF.md
# Network Controller Command and Status Register Block

This block is the host-facing control point of a descriptor-driven network controller. The host sees three registers. The status word holds latched interrupt causes in its upper byte, and live state fields from the command unit and the receive unit in its lower byte. The command word carries a command-unit field, a receive-unit field, an interrupt mask bit and a software-interrupt trigger bit. The pointer register is a general-purpose register that goes to a unit together with the command that needs it.

A command written to the command word is handed to its unit over a request/accept handshake. The command field reads back nonzero while the request is outstanding and returns to zero once the unit accepts it, so the host can poll for readiness. Interrupt causes are raised by single-cycle event inputs and by the software trigger. They are cleared by writing ones to the matching status bits. A single interrupt output reports whether any cause is pending and not masked. The two units are outside this block: their state and event lines are plain ports.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset, every cause bit, both command fields, the mask bit, the pointer register, both requests, the interrupt and the error flag are zero.
- R2: A one-cycle pulse on an event input sets its cause bit in the following cycle, and the bit stays set until cleared. Bit assignments: 15 command done, 14 frame received, 13 command unit left active, 12 receiver left ready, 11 management cycle done, 10 software interrupt, 8 flow-control pause.
- R3: A write to select 0 clears every cause bit whose data bit (15:8) is one and leaves the other bits unchanged. An event that arrives in the same cycle as its clear leaves the bit set.
- R4: The interrupt output is high exactly when some cause bit is set and command bit 8 (the mask, rewritten on every command write) is zero.
- R5: A command write with bit 9 set raises cause bit 10. Bit 9 always reads zero in both the status word and the command word.
- R6: A command write (select 1) with a valid command-unit code in bits 7:4 raises the command-unit request in the next cycle. The code and the current pointer value go out with the request. Valid codes are 1 start, 2 resume, 4 load statistics address, 5 dump statistics, 6 load base address, 7 dump and reset.
- R7: A valid receive-unit code in bits 2:0 does the same on the receive-unit side. Valid codes are 1 start, 2 resume, 4 abort, 6 load base address, 7 resume without resources, and 0 is a no-op.
- R8: An outstanding request holds its code and pointer steady until accept. The command-word field shows the pending code and reads zero from the cycle after accept.
- R9: Codes outside the valid sets (command unit 3 and 8 to 15, receive unit 3 and 5) are discarded: no request is made and the field stays zero.
- R10: A nonzero field written while that unit's previous command is still pending is ignored, and the error flag is set and stays set until reset.
- R11: Status bits 7:6 show the command-unit state input and bits 5:2 show the receive-unit state input. Receive-unit values: 0 idle, 1 suspended, 2 no resources, 4 ready, and bit 3 of the field additionally flags no buffer descriptors left.
- R12: A write to select 2 loads the pointer register. A later pointer write does not change the pointer attached to a request that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select: 0 status clear, 1 command, 2 pointer |
| host_wdata | input | PTR_W | Host write data |
| stat_word | output | 16 | Status word readback |
| cmd_word | output | 16 | Command word readback |
| ptr_word | output | PTR_W | Pointer register readback |
| cu_state | input | 2 | Command-unit state |
| ru_state | input | 4 | Receive-unit state |
| ev_cmd_done | input | 1 | Command completed event |
| ev_frame_rx | input | 1 | Frame received event |
| ev_cu_left | input | 1 | Command unit left active state |
| ev_ru_left | input | 1 | Receiver left ready state |
| ev_mgmt_done | input | 1 | Management cycle finished |
| ev_fc_pause | input | 1 | Flow-control pause event |
| cu_req | output | 1 | Command-unit request |
| cu_code | output | 4 | Command-unit code |
| cu_ptr | output | PTR_W | Pointer sent with the command-unit code |
| cu_ack | input | 1 | Command-unit accept |
| ru_req | output | 1 | Receive-unit request |
| ru_code | output | 3 | Receive-unit code |
| ru_ptr | output | PTR_W | Pointer sent with the receive-unit code |
| ru_ack | input | 1 | Receive-unit accept |
| irq | output | 1 | Interrupt output |
| cmd_err | output | 1 | Sticky lost-command flag |

## Verification
The handshake path is tried with a command that is accepted at once, a command held unaccepted across later pointer and command writes, valid codes on both units, and codes outside the valid sets. Together these separate correct capture from a lost command, a stale or overwritten pointer, and a wrong code filter. The cause path is tried with a lone event, a clear written with zeros, a clear colliding with a fresh event, the software trigger, and masked versus unmasked pending causes. These show whether the set and clear priority and the mask gating are right. The state fields are driven with suspended-type and no-descriptor values, which exposes any lane swap.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
   localparam int CU_W     = 4;
   localparam int RU_W     = 3;
   localparam int CAUSE_W  = 8;
   localparam logic [CAUSE_W-1:0] CAUSE_LIVE = 8'hFD;
   localparam logic [1:0] SEL_ACK = 2'd0;
   localparam logic [1:0] SEL_CMD = 2'd1;
   localparam logic [1:0] SEL_PTR = 2'd2;

   function automatic logic cu_code_ok(input logic [3:0] c);
      case (c)
         4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7: return 1'b1;
         default:                            return 1'b0;
      endcase
   endfunction

   function automatic logic ru_code_ok(input logic [3:0] c);
      case (c)
         4'd1, 4'd2, 4'd4, 4'd6, 4'd7: return 1'b1;
         default:                      return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/nic_cause_bank.sv
module nic_cause_bank #(
   parameter int               N    = 8,
   parameter logic [N-1:0]     LIVE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_v,
   input  logic [N-1:0] clr_v,
   output logic [N-1:0] cause_q
);
   generate
      if (N < 1) begin : g_bad
         $error("cause bank needs at least one bit");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= ((cause_q & ~clr_v) | set_v) & LIVE;
   end
endmodule

// File: rtl/nic_cmd_slot.sv
module nic_cmd_slot #(
   parameter int CODE_W = 4,
   parameter int PTR_W  = 32,
   parameter bit IS_CU  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CODE_W-1:0] code_in,
   input  logic [PTR_W-1:0]  ptr_in,
   input  logic              ack,
   output logic              req,
   output logic [CODE_W-1:0] code_q,
   output logic [PTR_W-1:0]  ptr_q,
   output logic              overrun
);
   logic [3:0] code_x;
   logic       legal;
   logic       attempt;

   generate
      if (CODE_W > 4 || CODE_W < 1) begin : g_bad
         $error("command field width must be 1 to 4");
      end
      if (IS_CU) begin : g_cu
         assign legal = nic_ctl_pkg::cu_code_ok(code_x);
      end else begin : g_ru
         assign legal = nic_ctl_pkg::ru_code_ok(code_x);
      end
   endgenerate

   assign code_x  = 4'(code_in);
   assign attempt = wr && (code_in != '0);
   assign overrun = attempt && req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req    <= 1'b0;
         code_q <= '0;
         ptr_q  <= '0;
      end else begin
         if (req && ack) begin
            req    <= 1'b0;
            code_q <= '0;
         end
         if (attempt && !req && legal) begin
            req    <= 1'b1;
            code_q <= code_in;
            ptr_q  <= ptr_in;
         end
      end
   end
endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs #(
   parameter int PTR_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_wr,
   input  logic [1:0]              host_sel,
   input  logic [PTR_W-1:0]        host_wdata,
   output logic [15:0]             stat_word,
   output logic [15:0]             cmd_word,
   output logic [PTR_W-1:0]        ptr_word,
   input  logic [1:0]              cu_state,
   input  logic [3:0]              ru_state,
   input  logic                    ev_cmd_done,
   input  logic                    ev_frame_rx,
   input  logic                    ev_cu_left,
   input  logic                    ev_ru_left,
   input  logic                    ev_mgmt_done,
   input  logic                    ev_fc_pause,
   output logic                    cu_req,
   output logic [3:0]              cu_code,
   output logic [PTR_W-1:0]        cu_ptr,
   input  logic                    cu_ack,
   output logic                    ru_req,
   output logic [2:0]              ru_code,
   output logic [PTR_W-1:0]        ru_ptr,
   input  logic                    ru_ack,
   output logic                    irq,
   output logic                    cmd_err
);
   import nic_ctl_pkg::*;

   generate
      if (PTR_W < 16 || PTR_W > 64) begin : g_bad
         $error("PTR_W must lie in 16..64");
      end
   endgenerate

   logic               wr_ack, wr_cmd, wr_ptr;
   logic [CAUSE_W-1:0] set_v, clr_v, cause_q;
   logic               mask_q;
   logic               cu_ovr, ru_ovr;

   assign wr_ack = host_wr && (host_sel == SEL_ACK);
   assign wr_cmd = host_wr && (host_sel == SEL_CMD);
   assign wr_ptr = host_wr && (host_sel == SEL_PTR);

   assign set_v = {ev_cmd_done, ev_frame_rx, ev_cu_left, ev_ru_left,
                   ev_mgmt_done, wr_cmd && host_wdata[9], 1'b0, ev_fc_pause};
   assign clr_v = wr_ack ? host_wdata[15:8] : '0;

   nic_cause_bank #(.N(CAUSE_W), .LIVE(CAUSE_LIVE)) u_cause (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .cause_q(cause_q));

   nic_cmd_slot #(.CODE_W(CU_W), .PTR_W(PTR_W), .IS_CU(1'b1)) u_cu (
      .clk(clk), .rst_n(rst_n), .wr(wr_cmd), .code_in(host_wdata[7:4]),
      .ptr_in(ptr_word), .ack(cu_ack), .req(cu_req), .code_q(cu_code),
      .ptr_q(cu_ptr), .overrun(cu_ovr));

   nic_cmd_slot #(.CODE_W(RU_W), .PTR_W(PTR_W), .IS_CU(1'b0)) u_ru (
      .clk(clk), .rst_n(rst_n), .wr(wr_cmd), .code_in(host_wdata[2:0]),
      .ptr_in(ptr_word), .ack(ru_ack), .req(ru_req), .code_q(ru_code),
      .ptr_q(ru_ptr), .overrun(ru_ovr));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= 1'b0;
         ptr_word <= '0;
         cmd_err  <= 1'b0;
      end else begin
         if (wr_cmd) mask_q <= host_wdata[8];
         if (wr_ptr) ptr_word <= host_wdata;
         if (cu_ovr || ru_ovr) cmd_err <= 1'b1;
      end
   end

   assign stat_word = {cause_q, cu_state, ru_state, 2'b00};
   assign cmd_word  = {7'b0, mask_q, cu_code, 1'b0, ru_code};
   assign irq       = (|cause_q) && !mask_q;
endmodule

// File: rtl/nic_ctl_chk.sv
module nic_ctl_chk #(
   parameter int PTR_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [15:0]      stat_word,
   input logic [15:0]      cmd_word,
   input logic [1:0]       cu_state,
   input logic [3:0]       ru_state,
   input logic             cu_req,
   input logic [3:0]       cu_code,
   input logic [PTR_W-1:0] cu_ptr,
   input logic             cu_ack,
   input logic             ru_req,
   input logic [2:0]       ru_code,
   input logic [PTR_W-1:0] ru_ptr,
   input logic             ru_ack,
   input logic             irq,
   input logic             cmd_err
);
   AST_CU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cu_req && !cu_ack |=> cu_req && $stable(cu_code) && $stable(cu_ptr)); // R8
   AST_RU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ru_req && !ru_ack |=> ru_req && $stable(ru_code) && $stable(ru_ptr)); // R8
   AST_CU_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      cu_req && cu_ack |=> !cu_req && cmd_word[7:4] == 4'd0); // R8
   AST_RU_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ru_req && ru_ack |=> !ru_req && cmd_word[2:0] == 3'd0); // R8
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_word[8] |-> !irq); // R4
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err); // R10
   AST_STATE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[7:2] == {cu_state, ru_state}); // R11
   AST_BIT9_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_word[9] && !cmd_word[9]); // R5
   AST_CU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cu_req |-> nic_ctl_pkg::cu_code_ok(cu_code)); // R9
   AST_RU_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      ru_req |-> nic_ctl_pkg::ru_code_ok({1'b0, ru_code})); // R9
endmodule

bind nic_ctl_regs nic_ctl_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/sim_nic_ctl_regs.sv
module sim_nic_ctl_regs;
   localparam int PW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_wr = 1'b0;
   logic [1:0]    host_sel = 2'd0;
   logic [PW-1:0] host_wdata = '0;
   logic [15:0]   stat_word, cmd_word;
   logic [PW-1:0] ptr_word, cu_ptr, ru_ptr;
   logic [1:0]    cu_state = 2'd0;
   logic [3:0]    ru_state = 4'd0;
   logic          ev_cmd_done = 0, ev_frame_rx = 0, ev_cu_left = 0;
   logic          ev_ru_left = 0, ev_mgmt_done = 0, ev_fc_pause = 0;
   logic          cu_req, ru_req, cu_ack = 0, ru_ack = 0, irq, cmd_err;
   logic [3:0]    cu_code;
   logic [2:0]    ru_code;

   int total = 0;
   int bad = 0;
   logic [35:0] cu_q[$];
   logic [35:0] ru_q[$];

   always #2 clk = ~clk;

   nic_ctl_regs #(.PTR_W(PW)) u0 (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic expect_cu(input logic [3:0] c, input logic [31:0] p);
      cu_q.push_back({c, p});
   endtask

   task automatic expect_ru(input logic [3:0] c, input logic [31:0] p);
      ru_q.push_back({c, p});
   endtask

   task automatic accept_cu();
      @(negedge clk); cu_ack = 1'b1;
      @(negedge clk); cu_ack = 1'b0;
   endtask

   task automatic accept_ru();
      @(negedge clk); ru_ack = 1'b1;
      @(negedge clk); ru_ack = 1'b0;
   endtask

   // monitor: pops the scoreboard at each handshake, one ns before the edge
   initial begin
      forever begin
         @(negedge clk); #1;
         if (cu_req && cu_ack) begin
            if (cu_q.size() == 0) check("R6 unexpected cu command", {28'd0, cu_code}, 32'hFFFF_FFFF);
            else begin
               logic [35:0] e;
               e = cu_q.pop_front();
               check("R6 cu code", {28'd0, cu_code}, {28'd0, e[35:32]});
               check("R12 cu pointer", cu_ptr, e[31:0]);
            end
         end
         if (ru_req && ru_ack) begin
            if (ru_q.size() == 0) check("R7 unexpected ru command", {29'd0, ru_code}, 32'hFFFF_FFFF);
            else begin
               logic [35:0] e;
               e = ru_q.pop_front();
               check("R7 ru code", {29'd0, ru_code}, {28'd0, e[35:32]});
               check("R12 ru pointer", ru_ptr, e[31:0]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 status", {16'd0, stat_word}, 32'd0);
      check("R1 command", {16'd0, cmd_word}, 32'd0);
      check("R1 pointer", ptr_word, 32'd0);
      check("R1 req/irq/err", {29'd0, cu_req, ru_req, irq | cmd_err}, 32'd0);

      // R11 state lanes
      cu_state = 2'd2; ru_state = 4'd9;
      @(negedge clk);
      check("R11 state fields", {26'd0, stat_word[7:2]}, {26'd0, 2'd2, 4'd9});
      ru_state = 4'd12;
      @(negedge clk);
      check("R11 no-descriptor ready", {28'd0, stat_word[5:2]}, 32'd12);

      // R2 event sets cause, R4 irq
      ev_frame_rx = 1; @(negedge clk); ev_frame_rx = 0;
      check("R2 frame cause", {16'd0, stat_word[15:8], 8'd0}, 32'h4000);
      check("R4 irq unmasked", {31'd0, irq}, 32'd1);
      hwrite(2'd0, 32'h0000_0000);
      check("R3 zero write keeps", {31'd0, stat_word[14]}, 32'd1);
      hwrite(2'd0, 32'h0000_4000);
      check("R3 one clears", {16'd0, stat_word[15:8], 8'd0}, 32'd0);
      check("R4 irq idle", {31'd0, irq}, 32'd0);

      // R4 mask
      hwrite(2'd1, 32'h0000_0100);
      ev_cmd_done = 1; ev_fc_pause = 1; @(negedge clk); ev_cmd_done = 0; ev_fc_pause = 0;
      check("R2 done+pause causes", {16'd0, stat_word[15:8], 8'd0}, 32'h8100);
      check("R4 masked irq", {31'd0, irq}, 32'd0);
      hwrite(2'd1, 32'h0000_0000);
      check("R4 unmasked irq", {31'd0, irq}, 32'd1);
      hwrite(2'd0, 32'h0000_8100);
      check("R4 cleared irq", {31'd0, irq}, 32'd0);

      // R5 software interrupt
      hwrite(2'd1, 32'h0000_0200);
      check("R5 swi cause", {16'd0, stat_word[15:8], 8'd0}, 32'h0400);
      check("R5 bit9 reads zero", {30'd0, stat_word[9], cmd_word[9]}, 32'd0);
      hwrite(2'd0, 32'h0000_0400);

      // R3 set wins over clear
      ev_mgmt_done = 1; ev_cu_left = 1; ev_ru_left = 1; @(negedge clk);
      ev_cu_left = 0; ev_ru_left = 0;
      host_wr = 1; host_sel = 2'd0; host_wdata = 32'h0000_3800;
      @(negedge clk);
      host_wr = 0; ev_mgmt_done = 0;
      check("R3 set beats clear", {16'd0, stat_word[15:8], 8'd0}, 32'h0800);
      hwrite(2'd0, 32'h0000_FF00);

      // R6 / R12 command-unit start with pointer
      hwrite(2'd2, 32'h1234_5678);
      check("R12 pointer load", ptr_word, 32'h1234_5678);
      expect_cu(4'd1, 32'h1234_5678);
      hwrite(2'd1, 32'h0000_0010);
      check("R6 cu request", {31'd0, cu_req}, 32'd1);
      check("R8 field pending", {28'd0, cmd_word[7:4]}, 32'd1);
      hwrite(2'd2, 32'hAAAA_5555);
      check("R12 pending pointer kept", cu_ptr, 32'h1234_5678);
      accept_cu();
      check("R8 field cleared", {16'd0, cmd_word}, 32'd0);
      check("R8 request dropped", {31'd0, cu_req}, 32'd0);

      // R10 overrun
      expect_cu(4'd2, 32'hAAAA_5555);
      hwrite(2'd1, 32'h0000_0020);
      repeat (3) @(negedge clk);
      check("R8 held without accept", {27'd0, cu_req, cu_code}, {27'd0, 1'b1, 4'd2});
      hwrite(2'd1, 32'h0000_0050);
      check("R10 ignored while pending", {28'd0, cu_code}, 32'd2);
      check("R10 error set", {31'd0, cmd_err}, 32'd1);
      accept_cu();
      check("R10 error sticky", {31'd0, cmd_err}, 32'd1);

      // R7 receive-unit commands, both fields at once
      hwrite(2'd2, 32'h00C0_FFEE);
      expect_cu(4'd7, 32'h00C0_FFEE);
      expect_ru(4'd4, 32'h00C0_FFEE);
      hwrite(2'd1, 32'h0000_0074);
      check("R7 ru request", {28'd0, ru_req, ru_code}, {28'd0, 1'b1, 3'd4});
      check("R6 dual field readback", {16'd0, cmd_word}, 32'h0074);
      accept_ru();
      check("R8 ru field cleared", {29'd0, cmd_word[2:0]}, 32'd0);
      accept_cu();
      expect_ru(4'd7, 32'h00C0_FFEE);
      hwrite(2'd1, 32'h0000_0007);
      accept_ru();

      // R9 illegal codes
      hwrite(2'd1, 32'h0000_0030);
      check("R9 cu code 3 dropped", {30'd0, cu_req, ru_req}, 32'd0);
      hwrite(2'd1, 32'h0000_0080);
      check("R9 cu code 8 dropped", {16'd0, cmd_word}, 32'd0);
      hwrite(2'd1, 32'h0000_0005);
      check("R9 ru code 5 dropped", {31'd0, ru_req}, 32'd0);
      hwrite(2'd1, 32'h0000_0003);
      check("R9 ru code 3 dropped", {16'd0, cmd_word}, 32'd0);

      repeat (2) @(negedge clk);
      check("R6 scoreboard drained", cu_q.size() + ru_q.size(), 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule